// File: doc/BRIEF.md
# Raster line interrupt generator

This block raises interrupt pulses at chosen points of the video raster. A raster timing block supplies the current line, the field parity, the dot position within the line, the line count of a frame, the last dot index of a line and whether the display is interlaced. The block compares these against programmed targets and emits a single-cycle pulse on each of its three interrupt outputs.

Two vertical interrupts each fire at the start of a programmed line. A horizontal interrupt fires at a programmed dot offset within a line. It has three modes: once per frame at a fixed line, every N lines using a running target, or every line. All programmed lines are in field units: line n is raster line 2n in an even field and 2n+1 in an odd field of an interlaced display. Software programs the block through a two-register write port. Masking and acknowledging the interrupts are left to the interrupt controller downstream.

Top module: `raster_irq_gen`

## Requirements
- R1: A write with `wr_sel`=0 loads the vertical targets: bits 25:16 set the line for `irq_v1` and bits 9:0 set the line for `irq_v2`. All other bits of `wr_data` are ignored.
- R2: A field line n matches raster line 2n+1 when `interlaced` and `cur_field` are both 1, and raster line 2n otherwise.
- R3: When the mapped raster line is not below `total_lines`, that interrupt never fires.
- R4: A write with `wr_sel`=1 loads the horizontal register: bits 9:0 are the line (or N), bits 13:12 are the mode, and bits 25:16 are the dot offset in the same half-dot units as `cur_dot`. Bits 31:26, 15:14 and 11:10 are ignored.
- R5: In mode 0 and in mode 3, `irq_h` fires on the mapped programmed line when `cur_dot` first reaches the offset.
- R6: In mode 1, `irq_h` fires at the running target. After each firing the target grows by N and then has half of `total_lines` (rounded down) taken away while it is larger than that half.
- R7: Mode 2 behaves as mode 1 with N equal to 1, whatever the line field holds.
- R8: Writing mode 1 or mode 2 sets the first target to `cur_line`/2 (rounded down) plus N, reduced in the same way as in R6.
- R9: A horizontal offset greater than `line_len` (the index of the last dot of a line) is treated as `line_len`.
- R10: Each interrupt is a registered pulse one clock wide. It is high in the cycle after the first cycle in which its line and dot conditions hold, and it fires at most once per raster line.
- R11: In a cycle where `total_lines` changes, no interrupt fires for the current line. The targets are then evaluated against the new count.
- R12: The vertical interrupts fire at the start of their line, which is dot 0.
- R13: Reset clears every output and every register. The vertical lines, the horizontal line, the horizontal mode and the horizontal offset all reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the vertical register, 1 selects the horizontal register |
| wr_data | input | 32 | Write data |
| cur_line | input | 11 | Current raster line |
| cur_field | input | 1 | Field parity, 1 means odd |
| interlaced | input | 1 | Display is interlaced |
| cur_dot | input | DOT_W | Position within the line, in half-dot units |
| line_len | input | DOT_W | Index of the last dot position of a line |
| total_lines | input | 11 | Number of raster lines per frame |
| irq_v1 | output | 1 | First vertical interrupt pulse |
| irq_v2 | output | 1 | Second vertical interrupt pulse |
| irq_h | output | 1 | Horizontal interrupt pulse |

## Verification
The bench keeps the default `DOT_W` but drives a very small raster of 12 to 16 lines with 8 dots per line, holding each dot for two clocks. At that size it can step through every position of several whole frames and compare each output in every cycle. This brings within reach the wrap of the every-N target at half the line count, the targets that lie beyond the last line, the switching of odd and even fields, and the clamp of the offset to the last dot. A directed sequence changes `total_lines` while one comparator already matches, to show that the change suppresses the pulse.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
  // field-unit line width fixed by the register format
  localparam int FLD_W  = 10;
  localparam int RL_W   = FLD_W + 1;  // raster line width
  localparam int HDOT_W = 10;
  localparam int NUM_V  = 2;

  // field positions decoded by software
  localparam int V1_LSB    = 16;
  localparam int V2_LSB    = 0;
  localparam int HLINE_LSB = 0;
  localparam int HMODE_LSB = 12;
  localparam int HDOT_LSB  = 16;

  typedef enum logic [1:0] {
    HM_FRAME   = 2'd0,
    HM_EVERY_N = 2'd1,
    HM_EVERY_1 = 2'd2,
    HM_RSVD    = 2'd3
  } hmode_e;
endpackage

// File: rtl/rirq_match.sv
module rirq_match
  import rirq_pkg::*;
#(
  parameter int DOT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FLD_W-1:0] tgt,
  input  logic             tgt_ok,
  input  logic [DOT_W-1:0] dot_off,
  input  logic [RL_W-1:0]  cur_line,
  input  logic             odd_sel,
  input  logic [DOT_W-1:0] cur_dot,
  input  logic [RL_W-1:0]  total_lines,
  input  logic             tot_chg,
  output logic             pulse
);
  logic [RL_W-1:0] mapped;
  logic [RL_W-1:0] line_q;
  logic            done;
  logic            newline;
  logic            match;

  assign mapped  = {tgt, odd_sel};
  assign newline = (cur_line != line_q);
  assign match   = tgt_ok && (mapped < total_lines) &&
                   (cur_line == mapped) && (cur_dot >= dot_off);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      done   <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      line_q <= cur_line;
      done   <= match | (done & ~newline);
      pulse  <= match & (~done | newline) & ~tot_chg;
    end
  end

  AST_ONE_PER_LINE: assert property (@(posedge clk) disable iff (rst)
    (done && !newline) |=> !pulse); // R10
  AST_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ($past(cur_line) < $past(total_lines))); // R3
  AST_DOT_REACHED: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ($past(cur_dot) >= $past(dot_off))); // R5
  AST_TOTAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    tot_chg |=> !pulse); // R11
endmodule

// File: rtl/rirq_hstep.sv
module rirq_hstep
  import rirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [FLD_W-1:0] load_n,
  input  logic [FLD_W-1:0] cur_half,
  input  logic [FLD_W-1:0] half,
  input  logic             advance,
  output logic [FLD_W-1:0] tgt,
  output logic             settled
);
  logic [FLD_W:0]   run;
  logic [FLD_W-1:0] step;
  logic [FLD_W:0]   half_x;

  assign half_x  = {1'b0, half};
  assign settled = (run <= half_x);
  assign tgt     = run[FLD_W-1:0];

  // one subtraction of half per cycle until the target is in range
  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      step <= '0;
    end else if (load) begin
      step <= load_n;
      run  <= {1'b0, cur_half} + {1'b0, load_n};
    end else if (advance) begin
      run <= run + {1'b0, step};
    end else if (!settled && half != '0) begin
      run <= run - half_x;
    end
  end

  AST_WRAP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance && !settled && half != '0) |=> (run < $past(run))); // R6
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import rirq_pkg::*;
#(
  parameter int DOT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [RL_W-1:0]  cur_line,
  input  logic             cur_field,
  input  logic             interlaced,
  input  logic [DOT_W-1:0] cur_dot,
  input  logic [DOT_W-1:0] line_len,
  input  logic [RL_W-1:0]  total_lines,
  output logic             irq_v1,
  output logic             irq_v2,
  output logic             irq_h
);
  logic [FLD_W-1:0]  v_line [NUM_V];
  logic [NUM_V-1:0]  v_irq;
  logic [FLD_W-1:0]  h_line;
  logic [HDOT_W-1:0] h_dot;
  hmode_e            h_mode;
  logic [RL_W-1:0]   tot_q;
  logic              tot_chg;
  logic              odd_sel;
  logic              unused_bits;

  assign unused_bits = ^{wr_data[31:26], wr_data[15:14], wr_data[11:10]};
  assign tot_chg     = (total_lines != tot_q);
  assign odd_sel     = interlaced & cur_field;

  // register writes
  hmode_e wr_mode;
  assign wr_mode = hmode_e'(wr_data[HMODE_LSB +: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_V; i++) v_line[i] <= '0;
      h_line <= '0;
      h_dot  <= '0;
      h_mode <= HM_FRAME;
      tot_q  <= '0;
    end else begin
      tot_q <= total_lines;
      if (wr_en && !wr_sel) begin
        v_line[0] <= wr_data[V1_LSB +: FLD_W];
        v_line[1] <= wr_data[V2_LSB +: FLD_W];
      end
      if (wr_en && wr_sel) begin
        h_line <= wr_data[HLINE_LSB +: FLD_W];
        h_dot  <= wr_data[HDOT_LSB +: HDOT_W];
        h_mode <= wr_mode;
      end
    end
  end

  // vertical comparators
  for (genvar gi = 0; gi < NUM_V; gi++) begin : g_vert
    rirq_match #(.DOT_W(DOT_W)) u_vmatch (
      .clk(clk), .rst(rst),
      .tgt(v_line[gi]), .tgt_ok(1'b1), .dot_off('0),
      .cur_line(cur_line), .odd_sel(odd_sel), .cur_dot(cur_dot),
      .total_lines(total_lines), .tot_chg(tot_chg),
      .pulse(v_irq[gi])
    );
  end
  assign irq_v1 = v_irq[0];
  assign irq_v2 = v_irq[1];

  // horizontal target selection
  logic             h_running;
  logic             h_load;
  logic [FLD_W-1:0] h_load_n;
  logic [FLD_W-1:0] run_tgt;
  logic             run_ok;
  logic [FLD_W-1:0] h_tgt;
  logic             h_ok;
  logic [DOT_W-1:0] hdot_x;
  logic [DOT_W-1:0] h_off;

  assign h_running = (h_mode == HM_EVERY_N) || (h_mode == HM_EVERY_1);
  assign h_load    = wr_en && wr_sel &&
                     ((wr_mode == HM_EVERY_N) || (wr_mode == HM_EVERY_1));
  assign h_load_n  = (wr_mode == HM_EVERY_1) ? FLD_W'(1)
                                             : wr_data[HLINE_LSB +: FLD_W];

  rirq_hstep u_hstep (
    .clk(clk), .rst(rst),
    .load(h_load), .load_n(h_load_n),
    .cur_half(cur_line[RL_W-1:1]), .half(total_lines[RL_W-1:1]),
    .advance(irq_h & h_running),
    .tgt(run_tgt), .settled(run_ok)
  );

  assign h_tgt  = h_running ? run_tgt : h_line;
  assign h_ok   = h_running ? run_ok : 1'b1;
  assign hdot_x = DOT_W'(h_dot);
  assign h_off  = (hdot_x > line_len) ? line_len : hdot_x;

  rirq_match #(.DOT_W(DOT_W)) u_hmatch (
    .clk(clk), .rst(rst),
    .tgt(h_tgt), .tgt_ok(h_ok), .dot_off(h_off),
    .cur_line(cur_line), .odd_sel(odd_sel), .cur_dot(cur_dot),
    .total_lines(total_lines), .tot_chg(tot_chg),
    .pulse(irq_h)
  );

  AST_H_OFF_CLAMP: assert property (@(posedge clk) disable iff (rst)
    irq_h |-> ($past(cur_dot) <= $past(line_len))); // R9
endmodule

// File: tb/raster_irq_gen_tb_top.sv
module raster_irq_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [10:0] cur_line = 11'd12;
  logic        cur_field = 1'b0;
  logic        interlaced = 1'b0;
  logic [10:0] cur_dot = '0;
  logic [10:0] line_len = 11'd7;
  logic [10:0] total_lines = 11'd12;
  logic        irq_v1, irq_v2, irq_h;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // model state (from the requirements)
  int mv1 = 0, mv2 = 0, mh_line = 0, mh_mode = 0, mh_dot = 0, mht = 0, mhn = 0;

  always #2 clk = ~clk;

  raster_irq_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_line(cur_line), .cur_field(cur_field), .interlaced(interlaced),
    .cur_dot(cur_dot), .line_len(line_len), .total_lines(total_lines),
    .irq_v1(irq_v1), .irq_v2(irq_v2), .irq_h(irq_h)
  );

  function automatic int wrapf(input int x, input int h);
    int r = x;
    while (h > 0 && r > h) r -= h;
    return r;
  endfunction

  function automatic int mapf(input int n);
    return 2 * n + ((interlaced && cur_field) ? 1 : 0);
  endfunction

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {irq_v1, irq_v2, irq_h};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {v1,v2,h}=%b expected %b (line %0d dot %0d)",
               tag, act, exp, cur_line, cur_dot);
    end
  endtask

  task automatic park();
    cur_line = total_lines;
    cur_dot  = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!sel) begin
      mv1 = int'(d[25:16]); mv2 = int'(d[9:0]);
    end else begin
      mh_line = int'(d[9:0]); mh_mode = int'(d[13:12]); mh_dot = int'(d[25:16]);
      if (mh_mode == 1 || mh_mode == 2) begin
        mhn = (mh_mode == 2) ? 1 : mh_line;
        mht = wrapf(int'(cur_line) / 2 + mhn, int'(total_lines) / 2);
      end
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic walk(input int nf, input int f0, input string tag);
    int tot, len, off, hm, ht;
    bit run;
    logic [2:0] e;
    tot = int'(total_lines); len = int'(line_len);
    for (int f = 0; f < nf; f++) begin
      cur_field = interlaced ? 1'((f0 + f) % 2) : 1'b0;
      for (int l = 0; l < tot; l++) begin
        for (int d = 0; d <= len; d++) begin
          run = (mh_mode == 1 || mh_mode == 2);
          ht  = run ? mht : mh_line;
          hm  = mapf(ht);
          off = (mh_dot > len) ? len : mh_dot;
          e[2] = (l == mapf(mv1)) && (mapf(mv1) < tot) && (d == 0);
          e[1] = (l == mapf(mv2)) && (mapf(mv2) < tot) && (d == 0);
          e[0] = (l == hm) && (hm < tot) && (d == off);
          if (e[0] && run) mht = wrapf(mht + mhn, tot / 2);
          cur_line = 11'(l); cur_dot = 11'(d);
          @(negedge clk); chk(tag, e);
          @(negedge clk); chk("R10", 3'b000);
        end
      end
    end
    park();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13", 3'b000);
    // reset values: every target on line 0, offset 0
    walk(1, 0, "R13");

    // vertical register with junk bits around the fields
    write_reg(1'b0, 32'hFC00_FC00 | (32'd3 << 16) | 32'd5);
    walk(2, 0, "R1 R12");

    interlaced = 1'b1;
    park();
    walk(2, 0, "R2");

    // v1 maps to 12/13, beyond a 12-line frame
    write_reg(1'b0, (32'd6 << 16) | 32'd5);
    walk(2, 0, "R3");

    // horizontal mode 0 with ignored bits set
    write_reg(1'b1, 32'hFC00_CC00 | (32'd3 << 16) | (32'd0 << 12) | 32'd2);
    walk(2, 1, "R4 R5");

    write_reg(1'b1, (32'd5 << 16) | (32'd3 << 12) | 32'd4);
    walk(2, 0, "R5");

    write_reg(1'b1, (32'd20 << 16) | (32'd0 << 12) | 32'd1);
    walk(2, 0, "R9");

    // every N lines, progressive, 14 lines
    interlaced = 1'b0; total_lines = 11'd14;
    park();
    write_reg(1'b1, (32'd1 << 16) | (32'd1 << 12) | 32'd2);
    walk(3, 0, "R6 R8");

    interlaced = 1'b1;
    park();
    write_reg(1'b1, (32'd6 << 16) | (32'd1 << 12) | 32'd5);
    walk(3, 0, "R6 R8");

    // every line with line field ignored, 13 lines
    interlaced = 1'b0; total_lines = 11'd13;
    park();
    write_reg(1'b1, (32'd2 << 16) | (32'd2 << 12) | 32'd4);
    walk(3, 0, "R7");

    // total change while a comparator matches
    total_lines = 11'd12;
    park();
    write_reg(1'b1, (32'd0 << 16) | (32'd0 << 12) | 32'd9);
    write_reg(1'b0, (32'd7 << 16) | 32'd9);
    cur_line = 11'd14; cur_dot = 11'd3;
    @(negedge clk); chk("R3", 3'b000);
    @(negedge clk); chk("R3", 3'b000);
    total_lines = 11'd16;
    @(negedge clk); chk("R11", 3'b000);
    repeat (3) begin @(negedge clk); chk("R11", 3'b000); end
    cur_line = 11'd15; cur_dot = 11'd0;
    @(negedge clk); chk("R11", 3'b000);
    @(negedge clk); chk("R11", 3'b000);
    cur_line = 11'd14;
    @(negedge clk); chk("R11", 3'b100);
    @(negedge clk); chk("R10", 3'b000);
    park();

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule